// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences the bus cycles of one DMA channel. A device raises a request; the sequencer asks for the system bus, waits for the grant, and then runs transfer cycles. During each cycle it gives the device an active-low acknowledge and pulses the memory and I/O strobes that match the selected transfer type. After each cycle the current address moves one step up or down, and the remaining word count drops by one. When the count wraps from zero to all ones, the sequencer flags terminal count and the channel goes dormant until it is loaded again.

The mode input sets when the bus is given up. Single mode gives it up after every cycle. Block mode keeps it until terminal count. Demand mode keeps it while the device holds its request. Cascade mode generates no cycles of its own: it passes a downstream controller's hold request upward and returns the grant as the acknowledge. A verify-type transfer runs full cycles with address and count updates but with every strobe held low. The channel's base address and count come in through a single load strobe. Priority between channels and the register interface belong to the surrounding logic.

Top module: `dma_seq_top`

## Requirements
- R1: While reset is low and in the first cycle after it, bus_req, every strobe and tc are 0, dack_n is 1, and addr and count are 0.
- R2: In single mode (mode 2'b00), each transfer cycle is followed by at least one cycle with bus_req low. A request that stays high produces one further transfer per bus acquisition.
- R3: In block mode (mode 2'b01), a single request starts a sequence. Once the grant arrives, transfer cycles follow back to back, whatever the request does, until the cycle that asserts tc.
- R4: In demand mode (mode 2'b10), transfers continue while dreq is high at the end of each cycle. When dreq is low at the end of a cycle, bus_req drops and no transfer occurs until dreq rises again.
- R5: In cascade mode (mode 2'b11), bus_req equals dreq and dack_n equals the inverse of bus_gnt. No strobe or tc is asserted, and addr and count hold.
- R6: Read type (xtype 2'b10) asserts mem_rd and io_wr, and only those, in each transfer cycle.
- R7: Write type (xtype 2'b01) asserts io_rd and mem_wr, and only those, in each transfer cycle.
- R8: Verify type (xtype 2'b00) and the unused code 2'b11 assert no strobe, while addr and count still step in every cycle.
- R9: tc is high exactly in the transfer cycle that starts with count zero. After that cycle, count holds all ones and further requests are ignored until load is pulsed. A load of N therefore gives N+1 transfers.
- R10: Outside cascade mode, dack_n is low only in transfer cycles, and a strobe is asserted only while dack_n is low.
- R11: After each transfer, addr becomes addr+1 when dir_dec is 0 and addr-1 when dir_dec is 1, modulo 2^AW.
- R12: No transfer cycle begins before bus_gnt has been seen with bus_req high, and bus_req stays high through every transfer cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dreq | input | 1 | Device request, or downstream hold request in cascade mode |
| bus_gnt | input | 1 | Bus grant from the system arbiter |
| mode | input | 2 | 00 single, 01 block, 10 demand, 11 cascade |
| xtype | input | 2 | 00 verify, 01 write, 10 read, 11 treated as verify |
| dir_dec | input | 1 | 1 selects an address decrement after each transfer |
| load | input | 1 | Loads addr and count and re-arms the channel |
| load_addr | input | AW | Start address |
| load_count | input | CW | Transfer count minus one |
| bus_req | output | 1 | Bus request to the system arbiter |
| dack_n | output | 1 | Acknowledge to the device, active low |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| addr | output | AW | Current address |
| count | output | CW | Current remaining count |
| tc | output | 1 | Terminal count, high in the last transfer cycle |

## Verification
The checker watches every cycle for local invariants. Strobes may only appear under an acknowledged transfer and only in legal read or write pairs. Address and count must take exactly one step after each transfer, tc may only fire in a cycle that starts at zero, and the bus must be released after a single-mode transfer. It also confirms that cascade mode only mirrors the handshake. Several properties span whole sequences, so only the bench scenarios can show them. These are: the total number of transfers for a given load, a block run staying unbroken after the request falls, a demand run pausing and resuming with dreq, and the channel staying dormant after terminal count until it is reloaded.

// File: rtl/dma_seq_pkg.sv
// Shared encodings for the DMA channel sequencer.
package dma_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE  = 2'b00,
        MODE_BLOCK   = 2'b01,
        MODE_DEMAND  = 2'b10,
        MODE_CASCADE = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        TYPE_VERIFY = 2'b00,
        TYPE_WRITE  = 2'b01,
        TYPE_READ   = 2'b10,
        TYPE_RSVD   = 2'b11
    } xfer_type_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARB,
        ST_MOVE,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } strobe_t;

endpackage

// File: rtl/dma_seq_ctrl.sv
// Sequencing state machine for one channel.
// Latches mode and type when a sequence starts, owns the bus handshake
// and the acknowledge, and goes dormant after terminal count until load.
// Assumes the arbiter keeps bus_gnt high while bus_req stays high.
module dma_seq_ctrl
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dreq,
    input  logic       bus_gnt,
    input  logic [1:0] mode_i,
    input  logic [1:0] type_i,
    input  logic       load,
    input  logic       tc_hit,
    output logic       xfer_cyc,
    output logic       bus_req,
    output logic       dack_n,
    output logic       casc_active,
    output xfer_mode_e cur_mode,
    output xfer_type_e cur_type
);

    seq_state_e state, state_nxt;
    logic       done;
    logic       start;

    // Start a sequence from idle on a live request when armed and not cascading.
    assign start = (state == ST_IDLE) && (mode_i != MODE_CASCADE) && dreq && !done;

    // Outputs decoded from the current state and the cascade pass-through.
    always_comb begin
        casc_active = (state == ST_IDLE) && (mode_i == MODE_CASCADE);
        xfer_cyc    = (state == ST_MOVE);
        if (casc_active) begin
            bus_req = dreq;
            dack_n  = !bus_gnt;
        end else begin
            bus_req = (state == ST_ARB) || (state == ST_MOVE);
            dack_n  = !xfer_cyc;
        end
    end

    // Next-state choice: each mode decides differently after a transfer.
    always_comb begin
        state_nxt = state;
        case (state)
            ST_IDLE: if (start) state_nxt = ST_ARB;
            ST_ARB:  if (bus_gnt) state_nxt = ST_MOVE;
            ST_MOVE: begin
                if (tc_hit) begin
                    state_nxt = ST_IDLE;
                end else begin
                    case (cur_mode)
                        MODE_BLOCK:  state_nxt = ST_MOVE;
                        MODE_DEMAND: state_nxt = dreq ? ST_MOVE : ST_IDLE;
                        default:     state_nxt = ST_GAP;
                    endcase
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register plus the mode and type captured at sequence start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_mode <= MODE_SINGLE;
            cur_type <= TYPE_VERIFY;
        end else begin
            state <= state_nxt;
            if (start) begin
                cur_mode <= xfer_mode_e'(mode_i);
                cur_type <= xfer_type_e'(type_i);
            end
        end
    end

    // Dormant flag: set by the terminal transfer, cleared by a reload.
    always_ff @(posedge clk) begin
        if (!rst_n)                 done <= 1'b0;
        else if (load)              done <= 1'b0;
        else if (xfer_cyc && tc_hit) done <= 1'b1;
    end

endmodule

// File: rtl/dma_seq_datapath.sv
// Current address and remaining-count registers.
// Loaded as a pair; stepped once per transfer cycle. A count of zero
// marks the last transfer, after which the count wraps to all ones.
module dma_seq_datapath #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_count,
    input  logic          step,
    input  logic          dir_dec,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] count,
    output logic          tc_hit
);

    localparam logic [AW-1:0] ADDR_ONE  = AW'(1);
    localparam logic [CW-1:0] COUNT_ONE = CW'(1);

    // Terminal condition: this transfer is the one that wraps the count.
    assign tc_hit = (count == '0);

    // Register update: load has priority over a transfer step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            count <= '0;
        end else if (load) begin
            addr  <= load_addr;
            count <= load_count;
        end else if (step) begin
            addr  <= dir_dec ? addr - ADDR_ONE : addr + ADDR_ONE;
            count <= count - COUNT_ONE;
        end
    end

endmodule

// File: rtl/dma_seq_strobe.sv
// Strobe decoder: maps the latched transfer type to the bus strobes
// during a transfer cycle. Verify and the unused code drive none.
module dma_seq_strobe
    import dma_seq_pkg::*;
(
    input  logic       active,
    input  xfer_type_e xtype_i,
    output strobe_t    strobes
);

    // Pick the read/write pair for the data direction of this type.
    always_comb begin
        strobes = '0;
        if (active) begin
            case (xtype_i)
                TYPE_READ: begin
                    strobes.mem_rd = 1'b1;
                    strobes.io_wr  = 1'b1;
                end
                TYPE_WRITE: begin
                    strobes.io_rd  = 1'b1;
                    strobes.mem_wr = 1'b1;
                end
                default: strobes = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_seq_top.sv
// Single-channel DMA transfer sequencer.
// Ties the control FSM, the address/count datapath and the strobe
// decoder together. Assumes load is pulsed only while the channel is idle.
module dma_seq_top
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dreq,
    input  logic          bus_gnt,
    input  logic [1:0]    mode,
    input  logic [1:0]    xtype,
    input  logic          dir_dec,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_count,
    output logic          bus_req,
    output logic          dack_n,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          io_rd,
    output logic          io_wr,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] count,
    output logic          tc
);

    logic       xfer_cyc;
    logic       tc_hit;
    logic       casc_active;
    xfer_mode_e cur_mode;
    xfer_type_e cur_type;
    strobe_t    strobes;

    dma_seq_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dreq       (dreq),
        .bus_gnt    (bus_gnt),
        .mode_i     (mode),
        .type_i     (xtype),
        .load       (load),
        .tc_hit     (tc_hit),
        .xfer_cyc   (xfer_cyc),
        .bus_req    (bus_req),
        .dack_n     (dack_n),
        .casc_active(casc_active),
        .cur_mode   (cur_mode),
        .cur_type   (cur_type)
    );

    dma_seq_datapath #(.AW(AW), .CW(CW)) dp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (load_addr),
        .load_count(load_count),
        .step      (xfer_cyc),
        .dir_dec   (dir_dec),
        .addr      (addr),
        .count     (count),
        .tc_hit    (tc_hit)
    );

    dma_seq_strobe strobe_i (
        .active (xfer_cyc),
        .xtype_i(cur_type),
        .strobes(strobes)
    );

    // Drive the strobe pins and the terminal-count flag.
    assign mem_rd = strobes.mem_rd;
    assign mem_wr = strobes.mem_wr;
    assign io_rd  = strobes.io_rd;
    assign io_wr  = strobes.io_wr;
    assign tc     = xfer_cyc && tc_hit;

endmodule

// File: rtl/dma_seq_chk.sv
// Cycle-level checker for dma_seq_top, bound onto every instance.
module dma_seq_chk
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dreq,
    input logic          bus_gnt,
    input logic          dir_dec,
    input logic          load,
    input logic          bus_req,
    input logic          dack_n,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          io_rd,
    input logic          io_wr,
    input logic [AW-1:0] addr,
    input logic [CW-1:0] count,
    input logic          tc,
    input logic          xfer_cyc,
    input logic          casc_active,
    input xfer_mode_e    cur_mode
);

    logic any_strobe;
    assign any_strobe = mem_rd | mem_wr | io_rd | io_wr;

    a_r10_strobe_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> (!dack_n && xfer_cyc));

    a_r6_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (io_wr && !io_rd && !mem_wr));

    a_r7_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (io_rd && !io_wr && !mem_rd));

    a_r11_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_cyc && !load) |=>
            (addr == ($past(dir_dec) ? AW'($past(addr) - AW'(1)) : AW'($past(addr) + AW'(1)))));

    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_cyc && !load) |=> (count == CW'($past(count) - CW'(1))));

    a_r9_tc_last: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (xfer_cyc && (count == '0)));

    a_r12_xfer_has_bus: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cyc |-> (bus_req && !dack_n));

    a_r2_single_release: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_cyc && cur_mode == MODE_SINGLE) |=> !bus_req);

    a_r5_casc_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        casc_active |-> ((bus_req == dreq) && (dack_n == !bus_gnt) && !any_strobe && !tc));

    a_r5_casc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (casc_active && !load) |=> ($stable(addr) && $stable(count)));

endmodule

bind dma_seq_top dma_seq_chk #(.AW(AW), .CW(CW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dreq       (dreq),
    .bus_gnt    (bus_gnt),
    .dir_dec    (dir_dec),
    .load       (load),
    .bus_req    (bus_req),
    .dack_n     (dack_n),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .addr       (addr),
    .count      (count),
    .tc         (tc),
    .xfer_cyc   (xfer_cyc),
    .casc_active(casc_active),
    .cur_mode   (cur_mode)
);

// File: tb/dma_seq_top_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a grant model with variable latency, a monitor
// that scores every transfer cycle, directed corner cases and seeded
// random sequences.
module dma_seq_top_tb_top;

    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dreq, bus_gnt, dir_dec, load;
    logic [1:0]    mode, xtype;
    logic [AW-1:0] load_addr;
    logic [CW-1:0] load_count;
    logic          bus_req, dack_n, mem_rd, mem_wr, io_rd, io_wr, tc;
    logic [AW-1:0] addr;
    logic [CW-1:0] count;

    int n_checks = 0;
    int n_errs   = 0;
    int m_xfers  = 0;
    int gnt_lat  = 1;
    logic [AW-1:0] m_addr;
    logic [CW-1:0] m_count;

    always #10 clk = !clk;

    dma_seq_top #(.AW(AW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .bus_gnt(bus_gnt),
        .mode(mode), .xtype(xtype), .dir_dec(dir_dec), .load(load),
        .load_addr(load_addr), .load_count(load_count),
        .bus_req(bus_req), .dack_n(dack_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_rd(io_rd), .io_wr(io_wr), .addr(addr), .count(count), .tc(tc)
    );

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_strobe(input logic [1:0] t);
        case (t)
            2'b10:   return 4'b1001;
            2'b01:   return 4'b0110;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string type_req(input logic [1:0] t);
        case (t)
            2'b10:   return "R6 read strobes";
            2'b01:   return "R7 write strobes";
            default: return "R8 verify strobes";
        endcase
    endfunction

    // Grant model: grant follows a held request after gnt_lat cycles.
    initial begin
        int waited;
        bus_gnt = 1'b0;
        waited  = 0;
        forever begin
            @(negedge clk);
            if (!bus_req) begin
                bus_gnt = 1'b0;
                waited  = 0;
            end else if (waited >= gnt_lat) begin
                bus_gnt = 1'b1;
            end else begin
                waited++;
            end
        end
    end

    // Monitor: scores each non-cascade transfer cycle against the model.
    initial begin
        logic xf, prev_single, prev_block;
        prev_single = 1'b0;
        prev_block  = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                xf = !dack_n && (mode != 2'b11);
                if (prev_single) chk(!bus_req, "R2 release after single", bus_req, 0);
                if (prev_block)  chk(xf, "R3 block back to back", xf, 1);
                if (xf) begin
                    chk(addr == m_addr, "R11 address", addr, m_addr);
                    chk(count == m_count, "R9 count", count, m_count);
                    chk(tc == (m_count == '0), "R9 tc", tc, m_count == '0);
                    chk({mem_rd, mem_wr, io_rd, io_wr} == exp_strobe(xtype), type_req(xtype),
                        {mem_rd, mem_wr, io_rd, io_wr}, exp_strobe(xtype));
                    chk(bus_req && bus_gnt, "R12 bus held", {bus_req, bus_gnt}, 2'b11);
                    m_addr  = dir_dec ? m_addr - AW'(1) : m_addr + AW'(1);
                    m_count = m_count - CW'(1);
                    m_xfers++;
                end else if (mode != 2'b11) begin
                    chk({mem_rd, mem_wr, io_rd, io_wr} == 4'b0, "R10 strobes idle",
                        {mem_rd, mem_wr, io_rd, io_wr}, 0);
                end
                prev_single = xf && (mode == 2'b00);
                prev_block  = xf && (mode == 2'b01) && !tc;
            end
        end
    end

    task automatic summary_and_end();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    endtask

    // Watchdog: an overlong run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog expired");
        summary_and_end();
    end

    task automatic do_load(input logic [AW-1:0] a, input logic [CW-1:0] c);
        @(negedge clk);
        load       = 1'b1;
        load_addr  = a;
        load_count = c;
        m_addr     = a;
        m_count    = c;
        @(negedge clk);
        load = 1'b0;
        #1;
        m_xfers = 0;
    endtask

    task automatic wait_xfers(input int target, input int limit);
        for (int i = 0; i < limit && m_xfers < target; i++) @(negedge clk);
        #2;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    initial begin
        int c;
        void'($urandom(32'h1d3a_5eed));
        rst_n = 1'b0; dreq = 1'b0; dir_dec = 1'b0; load = 1'b0;
        mode = 2'b00; xtype = 2'b00; load_addr = '0; load_count = '0;
        m_addr = '0; m_count = '0;
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        chk(!bus_req && dack_n && !tc && {mem_rd, mem_wr, io_rd, io_wr} == 0,
            "R1 reset outputs", {bus_req, dack_n, tc}, 3'b010);
        rst_n = 1'b1;
        #2;
        chk(addr == 0 && count == 0, "R1 reset regs", {addr, count}, 0);

        // R2: single mode, read, request held high, three transfers
        mode = 2'b00; xtype = 2'b10; gnt_lat = 1;
        do_load(16'h1000, 16'd2);
        dreq = 1'b1;
        wait_xfers(3, 200);
        chk(m_xfers == 3, "R2 single count", m_xfers, 3);
        settle(10);
        // R9: dormant after tc even with dreq high
        chk(m_xfers == 3 && !bus_req, "R9 dormant after tc", m_xfers, 3);
        chk(count == '1, "R9 count wraps", count, 16'hffff);
        chk(addr == 16'h1003, "R11 final up", addr, 16'h1003);
        dreq = 1'b0;

        // R3: block mode, write, one-cycle request
        mode = 2'b01; xtype = 2'b01; gnt_lat = 3;
        do_load(16'h0200, 16'd4);
        dreq = 1'b1;
        for (int i = 0; i < 50 && !bus_req; i++) @(negedge clk);
        dreq = 1'b0;
        wait_xfers(5, 200);
        settle(6);
        chk(m_xfers == 5, "R3 block total", m_xfers, 5);

        // R4: demand mode, verify, decrement, pause after three
        mode = 2'b10; xtype = 2'b00; dir_dec = 1'b1; gnt_lat = 0;
        do_load(16'h0005, 16'd9);
        dreq = 1'b1;
        wait_xfers(3, 200);
        dreq = 1'b0;
        settle(10);
        chk(m_xfers == 3, "R4 demand pause", m_xfers, 3);
        chk(!bus_req, "R4 bus released", bus_req, 0);
        chk(addr == 16'h0002, "R8 verify still steps", addr, 16'h0002);
        dreq = 1'b1;
        wait_xfers(10, 200);
        dreq = 1'b0;
        settle(6);
        chk(m_xfers == 10, "R4 demand resume total", m_xfers, 10);
        chk(addr == 16'hfffb, "R11 decrement wraps", addr, 16'hfffb);
        dir_dec = 1'b0;

        // R5: cascade pass-through
        do_load(16'h4444, 16'd7);
        mode = 2'b11; gnt_lat = 2;
        settle(2);
        chk(!bus_req && dack_n, "R5 cascade idle", {bus_req, dack_n}, 2'b01);
        dreq = 1'b1;
        settle(6);
        chk(bus_req == 1'b1, "R5 hold forwarded", bus_req, 1);
        chk(dack_n == !bus_gnt && bus_gnt, "R5 grant returned", dack_n, 0);
        chk({mem_rd, mem_wr, io_rd, io_wr, tc} == 0, "R5 no strobes", {mem_rd, mem_wr, io_rd, io_wr, tc}, 0);
        chk(addr == 16'h4444 && count == 16'd7, "R5 regs hold", addr, 16'h4444);
        dreq = 1'b0;
        settle(3);
        chk(!bus_req && dack_n, "R5 released", {bus_req, dack_n}, 2'b01);
        mode = 2'b00;

        // R12: no transfer while grant is withheld
        xtype = 2'b10; gnt_lat = 40;
        do_load(16'h0100, 16'd0);
        dreq = 1'b1;
        settle(20);
        chk(m_xfers == 0 && bus_req, "R12 waits for grant", m_xfers, 0);
        wait_xfers(1, 100);
        dreq = 1'b0;
        settle(4);
        chk(m_xfers == 1, "R9 load zero gives one", m_xfers, 1);

        // Seeded random sequences across modes, types and directions
        for (int k = 0; k < 24; k++) begin
            mode    = 2'($urandom % 3);
            xtype   = 2'($urandom % 4);
            dir_dec = 1'($urandom % 2);
            gnt_lat = $urandom % 4;
            c       = $urandom % 7;
            do_load(16'($urandom), 16'(c));
            dreq = 1'b1;
            wait_xfers(c + 1, 400);
            settle(8);
            chk(m_xfers == c + 1, "R9 random total", m_xfers, c + 1);
            chk(addr == m_addr, "R11 random final addr", addr, m_addr);
            dreq = 1'b0;
            settle(2);
        end

        summary_and_end();
    end

endmodule